// File: doc/BRIEF.md
# Multi-Channel Single-Unit DMA Transfer Engine

This block moves one unit of data per hardware request on one of eight channels. Each channel holds a source address, a destination address, a 16-bit transfer count and a 5-bit mode word. Software loads these through a write-only configuration port. A one-cycle pulse on a channel's request line queues one service for that channel. The engine then reads one unit from the source address on a synchronous memory bus and writes it to the destination address on the next cycle. After that it updates the channel's addresses and count as the mode requires.

The mode word chooses which side steps after the transfer: the destination, the source, both, or neither. It also chooses whether a step moves up or down, and how wide each access is: one, two or four bytes. A counter mode performs no bus access and only advances the source register by one. When a service brings a channel's count to zero, that channel's terminal-count interrupt line goes high and stays high. Mode words outside the defined set are refused: the engine makes no access, changes no register, and raises a sticky per-channel error line.

Top module: `udma_engine`

## Requirements
- R1: After reset no channel has a queued request, the read and write strobes are low, and every tc_irq and err_flag bit is 0.
- R2: A configuration write targets channel cfg_ch. cfg_sel picks the register: 0 is the source address, 1 the destination address, 2 the count (low 16 bits) and 3 the mode (low 5 bits). Writing the count clears that channel's tc_irq bit. Writing the mode clears its err_flag bit.
- R3: The mode's bits [1:0] give the access width: 00 means 1 byte, 01 means 2 bytes, 10 means 4 bytes. This code appears on mem_size. A data transfer reads once from the source address and, on the following cycle, writes that same data to the destination address. Read and write never happen in the same cycle.
- R4: Mode bits [4:2] = 000 add the access width to the destination after the transfer. 001 subtracts it. The source stays fixed in both cases.
- R5: Mode bits [4:2] = 010 add the access width to the source after the transfer. 011 subtracts it. The destination stays fixed in both cases.
- R6: Mode bits [4:2] = 100 add the access width to both addresses. 101 subtracts it from both. 110 leaves both addresses unchanged.
- R7: Mode 11100 (counter mode) drives no bus strobe, adds exactly 1 to the source and decrements the count.
- R8: Every accepted service decrements the count by one. tc_irq for the channel is set when the new count is 0 and stays set until the count is rewritten. A count of 0 wraps to 0xFFFF without setting tc_irq.
- R9: The read strobe appears in the third cycle after the cycle in which the request pulse is driven, and the write strobe in the fourth. A service occupies five engine cycles, or six for modes 100 and 101. So when requests are queued back to back, the next read follows 6 (or 7) cycles after the previous one.
- R10: When several channels have queued requests, they are served one at a time, lowest channel number first.
- R11: A mode word with bits [1:0] = 11, or with bits [4:2] = 111 and bits [1:0] other than 00, makes a service drive no bus strobe. It leaves the source, destination and count unchanged and sets that channel's err_flag bit, which stays set until the mode is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 3 | Channel addressed by the configuration write |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 mode |
| cfg_wdata | input | 32 | Configuration write data |
| dma_req | input | 8 | Per-channel request pulses, one service per cycle high |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Byte address for the current access |
| mem_size | output | 2 | Access width code: 00 one byte, 01 two, 10 four |
| mem_wdata | output | 32 | Write data, low bytes significant |
| mem_rdata | input | 32 | Read data, valid in the cycle after mem_rd |
| tc_irq | output | 8 | Per-channel terminal-count interrupt, sticky |
| err_flag | output | 8 | Per-channel reserved-mode error, sticky |

## Verification
The hardest situation to reach from the ports is two channels whose requests are queued in the same cycle. This is the only case in which the priority order and the gap between back-to-back services can be seen. Directed pairs pulse a higher and a lower channel together, with the lower channel first in a normal mode and then in a both-sides mode, and measure the distance between the two reads. Register state that no strobe shows, such as the source after counter mode or after a refused reserved mode, is brought out by switching the channel to a source-stepping mode and reading the next source address off the bus. Seeded random traffic over all modes, widths and small counts covers the rest.

// File: rtl/udma_pkg.sv
package udma_pkg;

   localparam int MODE_W = 5;

   typedef enum logic [2:0] {
      OP_DST_INC  = 3'd0,
      OP_DST_DEC  = 3'd1,
      OP_SRC_INC  = 3'd2,
      OP_SRC_DEC  = 3'd3,
      OP_BOTH_INC = 3'd4,
      OP_BOTH_DEC = 3'd5,
      OP_FIXED    = 3'd6,
      OP_COUNT    = 3'd7
   } udma_op_e;

   typedef enum logic [1:0] {
      SEL_SRC  = 2'd0,
      SEL_DST  = 2'd1,
      SEL_CNT  = 2'd2,
      SEL_MODE = 2'd3
   } udma_sel_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_RD,
      ST_WR,
      ST_UPD,
      ST_EXTRA,
      ST_DONE
   } udma_st_e;

   function automatic logic mode_reserved(input logic [MODE_W-1:0] m);
      return (m[1:0] == 2'b11) || ((m[4:2] == 3'b111) && (m[1:0] != 2'b00));
   endfunction

   function automatic logic [2:0] size_bytes(input logic [1:0] sz);
      case (sz)
         2'b00:   return 3'd1;
         2'b01:   return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

   function automatic logic op_src_moves(input udma_op_e op);
      return op inside {OP_SRC_INC, OP_SRC_DEC, OP_BOTH_INC, OP_BOTH_DEC, OP_COUNT};
   endfunction

   function automatic logic op_dst_moves(input udma_op_e op);
      return op inside {OP_DST_INC, OP_DST_DEC, OP_BOTH_INC, OP_BOTH_DEC};
   endfunction

   function automatic logic op_down(input udma_op_e op);
      return op inside {OP_DST_DEC, OP_SRC_DEC, OP_BOTH_DEC};
   endfunction

   function automatic logic op_dual(input udma_op_e op);
      return op inside {OP_BOTH_INC, OP_BOTH_DEC};
   endfunction

endpackage

// File: rtl/udma_chan.sv
module udma_chan
   import udma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              req,
   input  logic              take,
   input  logic              wb_src_en,
   input  logic [ADDR_W-1:0] wb_src,
   input  logic              wb_dst_en,
   input  logic [ADDR_W-1:0] wb_dst,
   input  logic              wb_cnt_en,
   input  logic [CNT_W-1:0]  wb_cnt,
   input  logic              err_set,
   output logic [ADDR_W-1:0] src,
   output logic [ADDR_W-1:0] dst,
   output logic [CNT_W-1:0]  cnt,
   output logic [MODE_W-1:0] mode,
   output logic              pending,
   output logic              tc,
   output logic              err
);

   logic wr_src, wr_dst, wr_cnt, wr_mode;
   logic unused_cfg;

   assign wr_src     = cfg_we && (cfg_sel == SEL_SRC);
   assign wr_dst     = cfg_we && (cfg_sel == SEL_DST);
   assign wr_cnt     = cfg_we && (cfg_sel == SEL_CNT);
   assign wr_mode    = cfg_we && (cfg_sel == SEL_MODE);
   assign unused_cfg = ^cfg_wdata;

   // configuration writes take precedence over engine write-back
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src <= '0;
         dst <= '0;
         cnt <= '0;
         mode <= '0;
      end else begin
         if (wr_src)         src <= cfg_wdata;
         else if (wb_src_en) src <= wb_src;
         if (wr_dst)         dst <= cfg_wdata;
         else if (wb_dst_en) dst <= wb_dst;
         if (wr_cnt)         cnt <= cfg_wdata[CNT_W-1:0];
         else if (wb_cnt_en) cnt <= wb_cnt;
         if (wr_mode)        mode <= cfg_wdata[MODE_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         tc      <= 1'b0;
         err     <= 1'b0;
      end else begin
         if (req)       pending <= 1'b1;
         else if (take) pending <= 1'b0;
         if (wr_cnt)                              tc <= 1'b0;
         else if (wb_cnt_en && (wb_cnt == '0))    tc <= 1'b1;
         if (wr_mode)      err <= 1'b0;
         else if (err_set) err <= 1'b1;
      end
   end

   // R8
   tc_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc) |-> (cnt == '0));

   // R2
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !wr_mode) |=> err);

   // R11
   err_keeps_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_set && !cfg_we) |=> $stable(cnt));

endmodule

// File: rtl/udma_prio.sv
module udma_prio #(
   parameter  int N     = 8,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] idx,
   output logic             any
);

   logic [N-1:0] lower_any;

   for (genvar i = 0; i < N; i++) begin : g_pri
      if (i == 0) begin : g_first
         assign lower_any[i] = 1'b0;
      end else begin : g_rest
         assign lower_any[i] = lower_any[i-1] | req[i-1];
      end
      assign grant[i] = req[i] & ~lower_any[i];
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) idx = idx | IDX_W'(i);
      end
   end

   assign any = |req;

endmodule

// File: rtl/udma_seq.sv
module udma_seq
   import udma_pkg::*;
#(
   parameter  int NUM_CH = 8,
   parameter  int ADDR_W = 32,
   parameter  int CNT_W  = 16,
   parameter  int DATA_W = 32,
   localparam int CH_W   = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              any_pend,
   input  logic [CH_W-1:0]   gnt_idx,
   input  logic [ADDR_W-1:0] ch_src,
   input  logic [ADDR_W-1:0] ch_dst,
   input  logic [CNT_W-1:0]  ch_cnt,
   input  logic [MODE_W-1:0] ch_mode,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              take,
   output logic [CH_W-1:0]   cur_ch,
   output logic              wb_src_en,
   output logic [ADDR_W-1:0] wb_src,
   output logic              wb_dst_en,
   output logic [ADDR_W-1:0] wb_dst,
   output logic              wb_cnt_en,
   output logic [CNT_W-1:0]  wb_cnt,
   output logic              err_set,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic [DATA_W-1:0] mem_wdata
);

   udma_st_e           st_q, st_d;
   logic [CH_W-1:0]    ch_q;
   logic [ADDR_W-1:0]  src_q, dst_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [MODE_W-1:0]  mode_q;
   udma_op_e           op;
   logic [2:0]         step;
   logic               use_dst;
   logic [ADDR_W-1:0]  base, stepped;

   assign op = udma_op_e'(mode_q[4:2]);
   assign step = (op == OP_COUNT) ? 3'd1 : size_bytes(mode_q[1:0]);

   // one shared address adder: the source side is stepped in ST_UPD,
   // the destination side in ST_UPD for single-side modes or ST_EXTRA
   assign use_dst = (st_q == ST_EXTRA) || (op_dst_moves(op) && !op_dual(op));
   assign base    = use_dst ? dst_q : src_q;
   assign stepped = op_down(op) ? (base - ADDR_W'(step)) : (base + ADDR_W'(step));

   assign wb_src    = stepped;
   assign wb_dst    = stepped;
   assign wb_cnt    = cnt_q - CNT_W'(1);
   assign cur_ch    = ch_q;
   assign mem_addr  = (st_q == ST_WR) ? dst_q : src_q;
   assign mem_size  = mode_q[1:0];
   assign mem_wdata = mem_rdata;

   always_comb begin
      st_d      = st_q;
      take      = 1'b0;
      err_set   = 1'b0;
      mem_rd    = 1'b0;
      mem_wr    = 1'b0;
      wb_src_en = 1'b0;
      wb_dst_en = 1'b0;
      wb_cnt_en = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (any_pend) begin
               take = 1'b1;
               st_d = ST_FETCH;
            end
         end
         ST_FETCH: begin
            if (mode_reserved(ch_mode)) begin
               err_set = 1'b1;
               st_d    = ST_IDLE;
            end else begin
               st_d = ST_RD;
            end
         end
         ST_RD: begin
            mem_rd = (op != OP_COUNT);
            st_d   = ST_WR;
         end
         ST_WR: begin
            mem_wr = (op != OP_COUNT);
            st_d   = ST_UPD;
         end
         ST_UPD: begin
            wb_cnt_en = 1'b1;
            wb_src_en = op_src_moves(op);
            wb_dst_en = op_dst_moves(op) && !op_dual(op);
            st_d      = op_dual(op) ? ST_EXTRA : ST_DONE;
         end
         ST_EXTRA: begin
            wb_dst_en = 1'b1;
            st_d      = ST_DONE;
         end
         ST_DONE: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ch_q   <= '0;
         src_q  <= '0;
         dst_q  <= '0;
         cnt_q  <= '0;
         mode_q <= '0;
      end else begin
         st_q <= st_d;
         if (take) ch_q <= gnt_idx;
         if (st_q == ST_FETCH) begin
            src_q  <= ch_src;
            dst_q  <= ch_dst;
            cnt_q  <= ch_cnt;
            mode_q <= ch_mode;
         end
      end
   end

   // cycles since the service left idle, for the length check
   logic [2:0] len_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               len_q <= '0;
      else if (st_q == ST_IDLE) len_q <= '0;
      else                      len_q <= len_q + 3'd1;
   end

   // R9
   xfer_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DONE) |-> (len_q == (op_dual(op) ? 3'd5 : 3'd4)));

   // R3
   rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R3
   wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> ($past(mem_rd) && ($past(mem_size) == mem_size)));

   // R11
   reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_set |=> (!mem_rd && !mem_wr && !wb_cnt_en));

endmodule

// File: rtl/udma_engine.sv
module udma_engine
   import udma_pkg::*;
#(
   parameter  int NUM_CH = 8,
   parameter  int ADDR_W = 32,
   parameter  int CNT_W  = 16,
   parameter  int DATA_W = 32,
   localparam int CH_W   = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CH_W-1:0]   cfg_ch,
   input  logic [1:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic [NUM_CH-1:0] dma_req,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [NUM_CH-1:0] tc_irq,
   output logic [NUM_CH-1:0] err_flag
);

   initial begin
      assert (NUM_CH >= 2 && (NUM_CH & (NUM_CH - 1)) == 0)
         else $error("udma_engine: NUM_CH must be a power of two >= 2");
      assert (DATA_W == 32)
         else $error("udma_engine: DATA_W must be 32 for 4-byte units");
      assert (ADDR_W > CNT_W && CNT_W >= 2)
         else $error("udma_engine: need ADDR_W > CNT_W >= 2");
      assert (ADDR_W > MODE_W)
         else $error("udma_engine: ADDR_W too narrow for mode writes");
   end

   logic [ADDR_W-1:0] src_a  [NUM_CH];
   logic [ADDR_W-1:0] dst_a  [NUM_CH];
   logic [CNT_W-1:0]  cnt_a  [NUM_CH];
   logic [MODE_W-1:0] mode_a [NUM_CH];
   logic [NUM_CH-1:0] pend_vec, grant, take_vec;
   logic [CH_W-1:0]   gnt_idx, cur_ch;
   logic              any_pend, take;
   logic              wb_src_en, wb_dst_en, wb_cnt_en, err_set;
   logic [ADDR_W-1:0] wb_src, wb_dst;
   logic [CNT_W-1:0]  wb_cnt;

   assign take_vec = take ? grant : '0;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic here;
      assign here = (cur_ch == CH_W'(i));
      udma_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chan_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_we    (cfg_we && (cfg_ch == CH_W'(i))),
         .cfg_sel   (cfg_sel),
         .cfg_wdata (cfg_wdata),
         .req       (dma_req[i]),
         .take      (take_vec[i]),
         .wb_src_en (wb_src_en && here),
         .wb_src    (wb_src),
         .wb_dst_en (wb_dst_en && here),
         .wb_dst    (wb_dst),
         .wb_cnt_en (wb_cnt_en && here),
         .wb_cnt    (wb_cnt),
         .err_set   (err_set && here),
         .src       (src_a[i]),
         .dst       (dst_a[i]),
         .cnt       (cnt_a[i]),
         .mode      (mode_a[i]),
         .pending   (pend_vec[i]),
         .tc        (tc_irq[i]),
         .err       (err_flag[i])
      );
   end

   udma_prio #(.N(NUM_CH)) prio_i (
      .req   (pend_vec),
      .grant (grant),
      .idx   (gnt_idx),
      .any   (any_pend)
   );

   udma_seq #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .any_pend  (any_pend),
      .gnt_idx   (gnt_idx),
      .ch_src    (src_a[cur_ch]),
      .ch_dst    (dst_a[cur_ch]),
      .ch_cnt    (cnt_a[cur_ch]),
      .ch_mode   (mode_a[cur_ch]),
      .mem_rdata (mem_rdata),
      .take      (take),
      .cur_ch    (cur_ch),
      .wb_src_en (wb_src_en),
      .wb_src    (wb_src),
      .wb_dst_en (wb_dst_en),
      .wb_dst    (wb_dst),
      .wb_cnt_en (wb_cnt_en),
      .wb_cnt    (wb_cnt),
      .err_set   (err_set),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_addr  (mem_addr),
      .mem_size  (mem_size),
      .mem_wdata (mem_wdata)
   );

   // R10
   one_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take_vec));

   // R10
   lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> ((pend_vec & (take_vec - NUM_CH'(1))) == '0));

endmodule

// File: tb/udma_engine_tb_top.sv
module udma_engine_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NCH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_ch = '0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic [7:0]  dma_req = '0;
   logic        mem_rd, mem_wr;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic [1:0]  mem_size;
   logic [7:0]  tc_irq, err_flag;

   always #(CLK_PERIOD/2) clk = ~clk;

   udma_engine dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .dma_req(dma_req),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .tc_irq(tc_irq), .err_flag(err_flag)
   );

   // one-state byte memory model
   logic [7:0] mem [0:4095];

   function automatic int nbytes(input logic [1:0] sz);
      return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
   endfunction

   function automatic logic [31:0] mem_get(input logic [31:0] a, input logic [1:0] sz);
      logic [31:0] v = '0;
      for (int k = 0; k < 4; k++)
         if (k < nbytes(sz)) v[k*8 +: 8] = mem[12'(a + 32'(k))];
      return v;
   endfunction

   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= mem_get(mem_addr, mem_size);
      if (mem_wr)
         for (int k = 0; k < 4; k++)
            if (k < nbytes(mem_size)) mem[12'(mem_addr + 32'(k))] <= mem_wdata[k*8 +: 8];
   end

   // channel model
   logic [31:0] m_src [NCH];
   logic [31:0] m_dst [NCH];
   logic [15:0] m_cnt [NCH];
   logic [4:0]  m_mode [NCH];
   logic [7:0]  m_tc, m_err;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   function automatic bit is_rsv(input logic [4:0] m);
      return (m[1:0] == 2'b11) || (m[4:2] == 3'b111 && m[1:0] != 2'b00);
   endfunction

   function automatic string side_tag(input logic [2:0] op);
      if (op < 3'd2) return "R4";
      if (op < 3'd4) return "R5";
      return "R6";
   endfunction

   task automatic cfg(input int ch, input int sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_sel = 2'(sel); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      case (sel)
         0: m_src[ch] = d;
         1: m_dst[ch] = d;
         2: begin m_cnt[ch] = d[15:0]; m_tc[ch] = 1'b0; end
         default: begin m_mode[ch] = d[4:0]; m_err[ch] = 1'b0; end
      endcase
   endtask

   task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d,
                        input logic [15:0] c, input logic [4:0] m);
      cfg(ch, 0, s); cfg(ch, 1, d); cfg(ch, 2, 32'(c)); cfg(ch, 3, 32'(m));
   endtask

   task automatic model_apply(input int ch);
      logic [2:0] op = m_mode[ch][4:2];
      logic [31:0] st;
      if (is_rsv(m_mode[ch])) begin
         m_err[ch] = 1'b1;
         return;
      end
      st = (op == 3'd7) ? 32'd1 : 32'(nbytes(m_mode[ch][1:0]));
      m_cnt[ch] = m_cnt[ch] - 16'd1;
      if (m_cnt[ch] == 16'd0) m_tc[ch] = 1'b1;
      case (op)
         3'd0: m_dst[ch] = m_dst[ch] + st;
         3'd1: m_dst[ch] = m_dst[ch] - st;
         3'd2: m_src[ch] = m_src[ch] + st;
         3'd3: m_src[ch] = m_src[ch] - st;
         3'd4: begin m_src[ch] = m_src[ch] + st; m_dst[ch] = m_dst[ch] + st; end
         3'd5: begin m_src[ch] = m_src[ch] - st; m_dst[ch] = m_dst[ch] - st; end
         3'd7: m_src[ch] = m_src[ch] + st;
         default: ;
      endcase
   endtask

   task automatic xfer(input int ch);
      logic [4:0]  m = m_mode[ch];
      logic [2:0]  op = m[4:2];
      bit          rsv = is_rsv(m);
      bit          bus = !rsv && (op != 3'd7);
      logic [31:0] exp_d = mem_get(m_src[ch], m[1:0]);
      int n_rd = 0, n_wr = 0, rd_at = 0, wr_at = 0;
      logic [31:0] rd_a = '0, wr_a = '0, wr_d = '0;
      logic [1:0]  rd_s = '0;
      @(negedge clk);
      dma_req[ch] = 1'b1;
      @(negedge clk);
      dma_req[ch] = 1'b0;
      for (int k = 1; k <= 10; k++) begin
         if (k > 1) @(negedge clk);
         if (mem_rd) begin n_rd++; rd_at = k; rd_a = mem_addr; rd_s = mem_size; end
         if (mem_wr) begin n_wr++; wr_at = k; wr_a = mem_addr; wr_d = mem_wdata; end
      end
      if (bus) begin
         chk("R3 read count", 32'(n_rd), 32'd1);
         chk("R3 write count", 32'(n_wr), 32'd1);
         chk("R9 read cycle", 32'(rd_at), 32'd3);
         chk("R9 write cycle", 32'(wr_at), 32'd4);
         chk({side_tag(op), " source address"}, rd_a, m_src[ch]);
         chk({side_tag(op), " destination address"}, wr_a, m_dst[ch]);
         chk("R3 size code", 32'(rd_s), 32'(m[1:0]));
         chk("R3 write data", wr_d, exp_d);
      end else begin
         chk(rsv ? "R11 no bus access" : "R7 no bus access", 32'(n_rd + n_wr), 32'd0);
      end
      model_apply(ch);
      chk("R8 tc_irq", 32'(tc_irq), 32'(m_tc));
      chk("R11 err_flag", 32'(err_flag), 32'(m_err));
   endtask

   task automatic pair(input int lo, input int hi, input int gap);
      logic [31:0] a_lo = m_src[lo], a_hi = m_src[hi];
      int at [2];
      logic [31:0] ad [2];
      int n = 0;
      @(negedge clk);
      dma_req[lo] = 1'b1; dma_req[hi] = 1'b1;
      @(negedge clk);
      dma_req = '0;
      for (int k = 1; k <= 20; k++) begin
         if (k > 1) @(negedge clk);
         if (mem_rd) begin
            if (n < 2) begin at[n] = k; ad[n] = mem_addr; end
            n++;
         end
      end
      chk("R10 service count", 32'(n), 32'd2);
      chk("R10 lower channel first", ad[0], a_lo);
      chk("R10 higher channel second", ad[1], a_hi);
      chk("R9 back-to-back gap", 32'(at[1] - at[0]), 32'(gap));
      model_apply(lo);
      model_apply(hi);
      chk("R8 tc_irq after pair", 32'(tc_irq), 32'(m_tc));
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 37 + 11);
      for (int c = 0; c < NCH; c++) begin
         m_src[c] = '0; m_dst[c] = '0; m_cnt[c] = '0; m_mode[c] = '0;
      end
      m_tc = '0; m_err = '0;
      void'($urandom(32'd7411));

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 tc_irq after reset", 32'(tc_irq), 32'd0);
      chk("R1 err_flag after reset", 32'(err_flag), 32'd0);
      chk("R1 strobes after reset", 32'({mem_rd, mem_wr}), 32'd0);
      repeat (3) @(negedge clk);
      chk("R1 no service without request", 32'({mem_rd, mem_wr}), 32'd0);

      // destination stepping, 2-byte, count reaches zero
      setup(0, 32'h100, 32'h800, 16'd2, 5'b00001);
      xfer(0);
      xfer(0);
      chk("R8 tc set at zero", 32'(tc_irq[0]), 32'd1);
      cfg(0, 2, 32'd5);
      chk("R2 count write clears tc", 32'(tc_irq[0]), 32'd0);

      // source decrement, 4-byte
      setup(1, 32'h600, 32'h900, 16'd3, 5'b01110);
      xfer(1);
      xfer(1);

      // both decrement, 1-byte, and both fixed
      setup(2, 32'h700, 32'hA00, 16'd4, 5'b10100);
      xfer(2);
      setup(2, 32'h710, 32'hA10, 16'd4, 5'b11001);
      xfer(2);
      xfer(2);

      // counter mode then source-stepping to expose the source
      setup(3, 32'h300, 32'hB00, 16'd2, 5'b11100);
      xfer(3);
      cfg(3, 3, 32'b01000);
      xfer(3);

      // reserved mode leaves registers alone; count 1 still fires later
      setup(4, 32'h400, 32'hC00, 16'd1, 5'b00011);
      xfer(4);
      chk("R11 err set", 32'(err_flag[4]), 32'd1);
      cfg(4, 3, 32'b01000);
      chk("R2 mode write clears err", 32'(err_flag[4]), 32'd0);
      xfer(4);
      setup(4, 32'h400, 32'hC00, 16'd1, 5'b11101);
      xfer(4);

      // count wrap from zero
      setup(6, 32'h500, 32'hD00, 16'd0, 5'b00000);
      xfer(6);
      chk("R8 wrap leaves tc clear", 32'(tc_irq[6]), 32'd0);

      // simultaneous requests: gap 6 after a single-side service, 7 after dual
      setup(2, 32'h200, 32'hE00, 16'd9, 5'b00000);
      setup(5, 32'h280, 32'hE80, 16'd9, 5'b01000);
      pair(2, 5, 6);
      setup(1, 32'h220, 32'hF00, 16'd9, 5'b10000);
      setup(6, 32'h2A0, 32'hF80, 16'd9, 5'b00001);
      pair(1, 6, 7);

      // seeded random traffic
      for (int it = 0; it < 80; it++) begin
         int ch = int'($urandom % 8);
         if (($urandom % 3) == 0 || it < 8) begin
            int r = int'($urandom % 16);
            logic [4:0] m;
            if (r < 13)      m = {3'($urandom % 7), 2'($urandom % 3)};
            else if (r < 14) m = 5'b11100;
            else if (r < 15) m = {3'($urandom % 8), 2'b11};
            else             m = 5'b11110;
            setup(ch, 32'd1024 + ($urandom % 2048), 32'd1024 + ($urandom % 2048),
                  16'(1 + ($urandom % 3)), m);
         end
         xfer(ch);
      end

      finished = 1;
      summary();
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         summary();
         $finish;
      end
   end

endmodule